// File: doc/BRIEF.md
# Store/Busy Pin Handshake Controller

This block sits between a shared open-drain store/busy line and the engine that copies volatile memory into nonvolatile cells. A store is requested when the line is pulled low from outside, or when the low-supply flag goes high. At the start of every store the block drives the line low itself for a fixed window, 20 µs, held as a cycle count. During that window it watches the synchronised line level. If the line does not come low, an external driver is holding it high and vetoing the store. In that case the block lets go of the line, reports a single-cycle abort and returns to idle without ever asking the engine to commit.

When the window completes cleanly, the block raises a commit request toward the transfer engine and holds it until the engine reports completion. Alongside this sequencing, the block decodes the active-low chip select and write enable into an access mode (standby, read, write, store) and a data-bus drive enable. A store in progress, or a low line, overrides both controls and forces the store mode.

Top module: `store_handshake_ctrl`

## Requirements
- R1: While reset is asserted and right after it, pull_o, commit_req_o and abort_o are 0 and, with cs_n_i high, mode_o is 0.
- R2: With the block idle, a falling edge of the line level (line_i) starts a store. pull_o rises three clock edges after the line first reads low: two synchroniser stages, then edge detection.
- R3: With the block idle, a rising edge of lowsupply_i starts a store with the same three-edge latency as R2.
- R4: Once started, pull_o stays high for exactly PULL_US*CLK_MHZ cycles. In the cycle after it drops, commit_req_o is 1, and it stays 1 until xfer_done_i is sampled high.
- R5: If the synchronised line reads high while pull_o is high, once SETTLE_CYCLES cycles have passed since the pull began, pull_o drops and abort_o is 1 for exactly one cycle. commit_req_o never rises for that store, and the block returns to idle. With an override present from the start, pull_o is high for SETTLE_CYCLES+1 cycles.
- R6: Store triggers that arrive while a store is in progress are ignored. A line held low, or a low-supply flag held high, after completion does not start another store.
- R7: With no store active and the line high, mode_o encodes 0=standby (cs_n_i=1, either we_n_i), 1=read (cs_n_i=0, we_n_i=1) and 2=write (cs_n_i=0, we_n_i=0). bus_oe_o is 1 only in read.
- R8: While a store is in progress, or the synchronised line is low, mode_o is 3 (store) and bus_oe_o is 0, whatever cs_n_i and we_n_i are.
- R9: A high line level seen only within the first SETTLE_CYCLES cycles of the pull does not abort the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the shared store/busy line (asynchronous) |
| lowsupply_i | input | 1 | Supply below switch threshold flag (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write enable, active low |
| xfer_done_i | input | 1 | Transfer engine finished the committed store |
| pull_o | output | 1 | Enable of the open-drain pull-down on the line |
| commit_req_o | output | 1 | Commit request to the transfer engine |
| abort_o | output | 1 | One-cycle pulse: store vetoed by an external driver |
| mode_o | output | 2 | Access mode: 0 standby, 1 read, 2 write, 3 store |
| bus_oe_o | output | 1 | Data bus drive enable |

## Verification
The hardest situation to reach is an override that fights the block's own pull-down. From the ports, a pulled-down line simply reads low. The bench therefore models the line as a wired node: it is low when the block pulls or an external source sinks it, and high whenever a stronger external driver is enabled. Enabling that driver across the whole window forces the abort path. Releasing it two cycles into the window places a high level inside the settle period only, which must not abort.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PULL   = 2'd1,
    SEQ_COMMIT = 2'd2,
    SEQ_ABORT  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_STORE   = 2'd3
  } acc_mode_t;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsc_trigger.sv
module hsc_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s_i,
  input  logic lowsup_s_i,
  output logic start_o
);
  logic line_prev_q, lowsup_prev_q;
  logic line_fall, lowsup_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev_q   <= 1'b1;
      lowsup_prev_q <= 1'b0;
    end else begin
      line_prev_q   <= line_s_i;
      lowsup_prev_q <= lowsup_s_i;
    end
  end

  always_comb begin
    line_fall   = line_prev_q & ~line_s_i;
    lowsup_rise = lowsup_s_i & ~lowsup_prev_q;
    start_o     = line_fall | lowsup_rise;
  end
endmodule

// File: rtl/hsc_pull_seq.sv
module hsc_pull_seq
  import hsc_pkg::*;
#(
  parameter int PULL_CYCLES   = 2500,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic line_hi_i,
  input  logic done_i,
  output logic pull_o,
  output logic req_o,
  output logic abort_o,
  output logic busy_o
);
  localparam int CW = $clog2(PULL_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT   = CW'(PULL_CYCLES - 1);
  localparam logic [CW-1:0] SETTLE_CNT = CW'(SETTLE_CYCLES);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic veto;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    veto    = (cnt_q >= SETTLE_CNT) && line_hi_i;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_PULL;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SEQ_PULL: begin
        if (veto) begin
          state_d = SEQ_ABORT;
        end else if (cnt_q == LAST_CNT) begin
          state_d = SEQ_COMMIT;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      SEQ_COMMIT: begin
        if (done_i) state_d = SEQ_IDLE;
      end
      SEQ_ABORT: begin
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pull_o  = (state_q == SEQ_PULL);
  assign req_o   = (state_q == SEQ_COMMIT);
  assign abort_o = (state_q == SEQ_ABORT);
  assign busy_o  = pull_o | req_o;

  // R5: an abort is caused by a high line seen during the pull
  assert_abort_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_o) |-> ($past(line_hi_i) && $past(pull_o)));

  // R5: abort is a single-cycle pulse
  assert_abort_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  // R4: commit is requested only straight after a pull window
  assert_commit_after_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(pull_o));

  // R4: the commit request holds until the engine is done
  assert_commit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !done_i) |=> req_o);
endmodule

// File: rtl/hsc_mode_dec.sv
module hsc_mode_dec
  import hsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       we_n_i,
  input  logic       store_i,
  output logic [1:0] mode_o,
  output logic       bus_oe_o
);
  acc_mode_t mode;

  always_comb begin
    if (store_i)     mode = MODE_STORE;
    else if (cs_n_i) mode = MODE_STANDBY;
    else if (we_n_i) mode = MODE_READ;
    else             mode = MODE_WRITE;
  end

  assign mode_o   = mode;
  assign bus_oe_o = ~store_i & ~cs_n_i & we_n_i;

  // R7: the data bus is only driven for a read
  assert_bus_oe_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> (mode_o == 2'd1));
endmodule

// File: rtl/store_handshake_ctrl.sv
module store_handshake_ctrl #(
  parameter int CLK_MHZ       = 125,
  parameter int PULL_US       = 20,
  parameter int SETTLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       lowsupply_i,
  input  logic       cs_n_i,
  input  logic       we_n_i,
  input  logic       xfer_done_i,
  output logic       pull_o,
  output logic       commit_req_o,
  output logic       abort_o,
  output logic [1:0] mode_o,
  output logic       bus_oe_o
);
  localparam int PULL_CYCLES = CLK_MHZ * PULL_US;

  logic [1:0] raw_in, sync_out;
  logic line_s, lowsup_s;
  logic start, busy;

  assign raw_in   = {lowsupply_i, line_i};
  assign line_s   = sync_out[0];
  assign lowsup_s = sync_out[1];

  hsc_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b01)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  hsc_trigger u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_s_i   (line_s),
    .lowsup_s_i (lowsup_s),
    .start_o    (start)
  );

  hsc_pull_seq #(
    .PULL_CYCLES   (PULL_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .line_hi_i (line_s),
    .done_i    (xfer_done_i),
    .pull_o    (pull_o),
    .req_o     (commit_req_o),
    .abort_o   (abort_o),
    .busy_o    (busy)
  );

  hsc_mode_dec u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .we_n_i   (we_n_i),
    .store_i  (busy | ~line_s),
    .mode_o   (mode_o),
    .bus_oe_o (bus_oe_o)
  );

  // R8: store mode while the line is pulled
  assert_store_mode_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |-> (mode_o == 2'd3 && !bus_oe_o));

  // R4: pulling and committing never overlap
  assert_no_pull_and_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_o && commit_req_o));

  // R6: a new pull never starts straight out of a commit
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req_o |=> !pull_o);
endmodule

// File: tb/store_handshake_ctrl_bench.sv
module store_handshake_ctrl_bench;
  localparam int CLK_MHZ  = 125;
  localparam int PULL_US  = 20;
  localparam int SETTLE   = 4;
  localparam int PULL_LEN = CLK_MHZ * PULL_US;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_low, ext_high, lowsup, cs_n, we_n, done;
  logic pull, req, abort_p, bus_oe;
  logic [1:0] mode;
  logic line;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  // wired line: a strong external driver wins over any pull-down
  assign line = ext_high ? 1'b1 : ~(pull | ext_low);

  store_handshake_ctrl #(
    .CLK_MHZ(CLK_MHZ), .PULL_US(PULL_US), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)
  ) u_store_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .line_i(line), .lowsupply_i(lowsup),
    .cs_n_i(cs_n), .we_n_i(we_n), .xfer_done_i(done),
    .pull_o(pull), .commit_req_o(req), .abort_o(abort_p),
    .mode_o(mode), .bus_oe_o(bus_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req_tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic wait_pull(output int n);
    n = 0;
    do begin tick(); n++; end while (!pull && n < 20);
  endtask

  // kind 1: raise lowsup at step; kind 2: release ext_high at step
  task automatic run_pull(input int act_at, input int kind,
                          output int len, output bit saw_req);
    len = 0; saw_req = 0;
    while (pull) begin
      len++;
      if (req) saw_req = 1;
      if (len == act_at && kind == 1) lowsup = 1'b1;
      if (len == act_at && kind == 2) ext_high = 1'b0;
      if (len == 10) begin
        cs_n = 1'b0; we_n = 1'b1;
        #1;
        check("R8 store mode during pull", mode, 3);
        check("R8 bus idle during pull", bus_oe, 0);
        cs_n = 1'b1;
      end
      tick();
    end
  endtask

  task automatic finish_commit(input string tag);
    check({tag, " commit after pull"}, req, 1);
    repeat (4) tick();
    check({tag, " commit held"}, req, 1);
    done = 1'b1; tick(); done = 1'b0;
    check({tag, " commit cleared by done"}, req, 0);
  endtask

  task automatic quiet(input int cycles, input string tag);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (pull) hits++;
    end
    check(tag, hits, 0);
  endtask

  typedef struct packed {
    logic       cs_n;
    logic       we_n;
    logic [1:0] mode;
    logic       oe;
  } mode_vec_t;

  localparam mode_vec_t MODE_TBL [4] = '{
    '{cs_n:1'b1, we_n:1'b1, mode:2'd0, oe:1'b0},
    '{cs_n:1'b1, we_n:1'b0, mode:2'd0, oe:1'b0},
    '{cs_n:1'b0, we_n:1'b1, mode:2'd1, oe:1'b1},
    '{cs_n:1'b0, we_n:1'b0, mode:2'd2, oe:1'b0}
  };

  initial begin
    int n, len;
    bit rq;
    rst_n = 1'b0; ext_low = 0; ext_high = 0; lowsup = 0;
    cs_n = 1'b1; we_n = 1'b1; done = 0;
    repeat (3) tick();
    check("R1 pull in reset", pull, 0);
    check("R1 commit in reset", req, 0);
    check("R1 abort in reset", abort_p, 0);
    check("R1 mode in reset", mode, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 pull after reset", pull, 0);

    // R7 table walk
    foreach (MODE_TBL[i]) begin
      cs_n = MODE_TBL[i].cs_n; we_n = MODE_TBL[i].we_n;
      tick();
      check("R7 mode decode", mode, MODE_TBL[i].mode);
      check("R7 bus enable", bus_oe, MODE_TBL[i].oe);
    end
    cs_n = 1'b1; we_n = 1'b1;

    // R3: low-supply trigger, full store
    lowsup = 1'b1;
    wait_pull(n);
    check("R3 lowsupply start latency", n, 3);
    run_pull(0, 0, len, rq);
    check("R4 pull length", len, PULL_LEN);
    check("R4 no commit during pull", rq, 0);
    finish_commit("R4");
    quiet(20, "R6 held lowsupply no restart");
    lowsup = 1'b0;
    repeat (5) tick();

    // R2: external low trigger, held through the store
    ext_low = 1'b1;
    cs_n = 1'b0; we_n = 1'b0;
    repeat (3) tick();
    check("R8 store mode on low line", mode, 3);
    check("R2 pull started", pull, 1);
    cs_n = 1'b1; we_n = 1'b1;
    run_pull(100, 1, len, rq);
    check("R6 retrigger ignored, pull length", len, PULL_LEN);
    finish_commit("R2");
    quiet(30, "R6 held low line no restart");
    ext_low = 1'b0; lowsup = 1'b0;
    repeat (5) tick();

    // R5: external override across the whole window
    ext_high = 1'b1; lowsup = 1'b1;
    wait_pull(n);
    check("R5 pull started under override", pull, 1);
    run_pull(0, 0, len, rq);
    check("R5 aborted pull length", len, SETTLE + 1);
    check("R5 abort pulse", abort_p, 1);
    check("R5 no commit", req, 0);
    tick();
    check("R5 abort one cycle", abort_p, 0);
    check("R5 idle after abort", req, 0);
    ext_high = 1'b0; lowsup = 1'b0;
    repeat (5) tick();
    check("R5 standby after abort", mode, 0);

    // R9: override only inside the settle window
    ext_high = 1'b1; lowsup = 1'b1;
    wait_pull(n);
    run_pull(2, 2, len, rq);
    check("R9 settle high ignored, pull length", len, PULL_LEN);
    check("R9 no abort", abort_p, 0);
    finish_commit("R9");
    lowsup = 1'b0;
    repeat (5) tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule